// File: doc/BRIEF.md
# Pipelined Tower-Field AES Byte Substitution

This block performs the forward AES byte substitution on one byte per clock. It does not use a stored table. The input byte is carried by a linear change of basis into a two-level extension field. That field is built as a quadratic extension over a 4-bit field, whose reduction polynomial is x^4+x+1. The block finds the multiplicative inverse there using only 4-bit multiplies, squares and one 4-bit inversion. A single merged matrix then maps the result back to the AES polynomial basis (x^8+x^4+x^3+x+1) and applies the AES affine step. The constant 0x63 is added last.

A parameter sets the number of register cuts placed inside the inverse datapath: 0, 2 or 3. With 0 the block is purely combinational. With 2 it registers after the norm computation and after the 4-bit inversion. With 3 it also registers after the subfield multiplications. A valid bit travels alongside the data through the same registers. The output is therefore a valid-qualified byte with a fixed latency and no stall path, which suits a fully unrolled round pipeline that never feeds back. The change-of-basis matrices and the subfield constant are derived at elaboration from the field definitions, so no magic constants are hard-coded.

Top module: `sbox_tower_pipe`

## Requirements
- R1: For every input byte 0x00..0xFF, the output byte equals the standard AES forward S-box value: the multiplicative inverse modulo x^8+x^4+x^3+x+1, then the AES affine transform, with constant 0x63. This holds for STAGES of 0, 2 and 3.
- R2: Input 0x00 produces output 0x63, because the inverse of zero is taken as zero.
- R3: `out_valid` equals `in_valid` delayed by exactly STAGES clock cycles, and `out_byte` belongs to the byte presented at that same earlier cycle.
- R4: With STAGES = 0, `out_byte` and `out_valid` follow the inputs within the same cycle, with no register on the path.
- R5: One new byte is accepted every clock. Back-to-back valid inputs give back-to-back valid outputs, in order, with none lost or repeated.
- R6: While `rst_n` is low, a configuration with STAGES > 0 holds `out_valid` low.
- R7: A cycle with `in_valid` low produces no valid output STAGES cycles later. Bubbles stay bubbles.
- R8: The output never equals its input byte, and never equals the bitwise complement of its input byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline valid and data registers |
| in_valid | input | 1 | Qualifies `in_byte` in this cycle |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | Qualifies `out_byte` |
| out_byte | output | 8 | Substituted byte |

## Verification
The bound checker watches four properties on every cycle:
- the valid bit's exact delay of STAGES cycles;
- the zero-to-0x63 mapping;
- the absence of fixed points and anti-fixed points;
- the quiet output during reset.

Only the bench's scenarios can show that all 256 values match the true S-box in each of the three stage settings, and that the in-order one-per-clock stream survives both dense sweeps and sweeps broken by bubbles. The scoreboard ties each output to its issue cycle. This exposes any drift in latency, and any output that appears when nothing was sent.

// File: rtl/sbx_tower_pkg.sv
package sbx_tower_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    typedef logic [BYTE_W-1:0]             byte_t;
    typedef logic [NIB_W-1:0]              nib_t;
    typedef logic [BYTE_W-1:0][BYTE_W-1:0] mat8_t;  // [j] = image of basis bit j

    localparam byte_t AFF_CONST = 8'h63;

    // GF(2^4) product, reduction by x^4 + x + 1
    function automatic nib_t g16_mul(nib_t a, nib_t b);
        nib_t acc = '0;
        nib_t x   = a;
        for (int i = 0; i < NIB_W; i++) begin
            if (b[i]) acc ^= x;
            x = {x[2:0], 1'b0} ^ (x[3] ? 4'h3 : 4'h0);
        end
        return acc;
    endfunction

    function automatic nib_t g16_sq(nib_t a);
        return g16_mul(a, a);
    endfunction

    // a^14 = a^-1 for a != 0, and 0 maps to 0
    function automatic nib_t g16_inv(nib_t a);
        nib_t p2 = g16_sq(a);
        nib_t p4 = g16_sq(p2);
        nib_t p8 = g16_sq(p4);
        return g16_mul(g16_mul(p2, p4), p8);
    endfunction

    // GF(2^8) product, reduction by x^8 + x^4 + x^3 + x + 1
    function automatic byte_t g256_mul(byte_t a, byte_t b);
        byte_t acc = '0;
        byte_t x   = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc ^= x;
            x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
        end
        return acc;
    endfunction

    // smallest constant c making y^2 + y + c irreducible over GF(2^4)
    function automatic nib_t find_lambda();
        for (int c = 1; c < 16; c++) begin
            bit has_root = 1'b0;
            for (int y = 0; y < 16; y++) begin
                if ((g16_mul(4'(y), 4'(y)) ^ 4'(y) ^ 4'(c)) == 4'h0) has_root = 1'b1;
            end
            if (!has_root) return 4'(c);
        end
        return 4'h0;
    endfunction

    // element of GF(2^8) that is a root of x^4 + x + 1
    function automatic byte_t find_omega();
        for (int c = 2; c < 256; c++) begin
            byte_t cb = 8'(c);
            byte_t c2 = g256_mul(cb, cb);
            if ((g256_mul(c2, c2) ^ cb ^ 8'h01) == 8'h00) return cb;
        end
        return 8'h00;
    endfunction

    function automatic byte_t lift_nib(nib_t n, byte_t w);
        byte_t acc = '0;
        byte_t p   = 8'h01;
        for (int i = 0; i < NIB_W; i++) begin
            if (n[i]) acc ^= p;
            p = g256_mul(p, w);
        end
        return acc;
    endfunction

    function automatic byte_t find_ext_root(byte_t w, nib_t lam);
        byte_t li = lift_nib(lam, w);
        for (int c = 2; c < 256; c++) begin
            byte_t cb = 8'(c);
            if ((g256_mul(cb, cb) ^ cb ^ li) == 8'h00) return cb;
        end
        return 8'h00;
    endfunction

    function automatic byte_t mat_apply(mat8_t m, byte_t x);
        byte_t acc = '0;
        for (int j = 0; j < BYTE_W; j++) begin
            if (x[j]) acc ^= m[j];
        end
        return acc;
    endfunction

    // tower coordinates {hi, lo} -> AES polynomial basis
    function automatic mat8_t tower_to_aes();
        mat8_t m;
        byte_t w  = find_omega();
        byte_t yr = find_ext_root(w, find_lambda());
        for (int j = 0; j < NIB_W; j++) begin
            m[j]         = lift_nib(4'(1 << j), w);
            m[j + NIB_W] = g256_mul(lift_nib(4'(1 << j), w), yr);
        end
        return m;
    endfunction

    // AES polynomial basis -> tower coordinates, found by search
    function automatic mat8_t aes_to_tower();
        mat8_t m = '0;
        mat8_t u = tower_to_aes();
        for (int j = 0; j < BYTE_W; j++) begin
            for (int t = 0; t < 256; t++) begin
                if (mat_apply(u, 8'(t)) == 8'(1 << j)) m[j] = 8'(t);
            end
        end
        return m;
    endfunction

    function automatic byte_t affine_linear(byte_t x);
        byte_t r;
        for (int i = 0; i < BYTE_W; i++) begin
            r[i] = x[i] ^ x[(i + 4) % 8] ^ x[(i + 5) % 8] ^ x[(i + 6) % 8] ^ x[(i + 7) % 8];
        end
        return r;
    endfunction

    // back-map merged with the affine linear part
    function automatic mat8_t out_matrix();
        mat8_t m;
        mat8_t u = tower_to_aes();
        for (int j = 0; j < BYTE_W; j++) m[j] = affine_linear(u[j]);
        return m;
    endfunction

    localparam nib_t TOWER_LAMBDA = find_lambda();

endpackage

// File: rtl/sbx_pipe_reg.sv
module sbx_pipe_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vin,
    input  logic [WIDTH-1:0] din,
    output logic             vout,
    output logic [WIDTH-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vout <= 1'b0;
            dout <= '0;
        end else begin
            vout <= vin;
            dout <= din;
        end
    end
endmodule

// File: rtl/sbx_front.sv
module sbx_front
    import sbx_tower_pkg::*;
#(
    parameter mat8_t MAP_IN = '0
) (
    input  byte_t din,
    output nib_t  hi,
    output nib_t  lo,
    output nib_t  norm
);
    byte_t tw;

    always_comb begin
        tw   = mat_apply(MAP_IN, din);
        hi   = tw[BYTE_W-1:NIB_W];
        lo   = tw[NIB_W-1:0];
        // norm of (hi*Y + lo) where Y^2 = Y + lambda
        norm = g16_mul(TOWER_LAMBDA, g16_sq(hi)) ^ g16_mul(hi, lo) ^ g16_sq(lo);
    end
endmodule

// File: rtl/sbx_nib_inv.sv
module sbx_nib_inv
    import sbx_tower_pkg::*;
(
    input  nib_t din,
    output nib_t dout
);
    always_comb dout = g16_inv(din);
endmodule

// File: rtl/sbx_recomb.sv
module sbx_recomb
    import sbx_tower_pkg::*;
(
    input  nib_t hi,
    input  nib_t lo,
    input  nib_t ninv,
    output nib_t qhi,
    output nib_t qlo
);
    always_comb begin
        qhi = g16_mul(hi, ninv);
        qlo = g16_mul(hi ^ lo, ninv);
    end
endmodule

// File: rtl/sbox_tower_pipe.sv
module sbox_tower_pipe
    import sbx_tower_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       out_valid,
    output logic [7:0] out_byte
);
    localparam bit    CUT_NORM = (STAGES >= 2);
    localparam bit    CUT_INV  = (STAGES >= 2);
    localparam bit    CUT_MUL  = (STAGES >= 3);
    localparam int    W_A      = 3 * NIB_W;
    localparam int    W_M      = 2 * NIB_W;
    localparam mat8_t MAP_IN   = aes_to_tower();
    localparam mat8_t MAP_OUT  = out_matrix();

    nib_t a_hi, a_lo, a_norm;
    nib_t b_hi, b_lo, b_norm, b_ninv;
    nib_t c_hi, c_lo, c_ninv, c_qhi, c_qlo;
    nib_t d_qhi, d_qlo;
    logic vb, vc, vd;

    sbx_front #(.MAP_IN(MAP_IN)) u_front (
        .din (in_byte),
        .hi  (a_hi),
        .lo  (a_lo),
        .norm(a_norm)
    );

    generate
        if (CUT_NORM) begin : g_cut_norm
            sbx_pipe_reg #(.WIDTH(W_A)) u_reg (
                .clk (clk),
                .rst_n(rst_n),
                .vin (in_valid),
                .din ({a_hi, a_lo, a_norm}),
                .vout(vb),
                .dout({b_hi, b_lo, b_norm})
            );
        end else begin : g_pass_norm
            assign {b_hi, b_lo, b_norm} = {a_hi, a_lo, a_norm};
            assign vb = in_valid;
        end
    endgenerate

    sbx_nib_inv u_inv (
        .din (b_norm),
        .dout(b_ninv)
    );

    generate
        if (CUT_INV) begin : g_cut_inv
            sbx_pipe_reg #(.WIDTH(W_A)) u_reg (
                .clk (clk),
                .rst_n(rst_n),
                .vin (vb),
                .din ({b_hi, b_lo, b_ninv}),
                .vout(vc),
                .dout({c_hi, c_lo, c_ninv})
            );
        end else begin : g_pass_inv
            assign {c_hi, c_lo, c_ninv} = {b_hi, b_lo, b_ninv};
            assign vc = vb;
        end
    endgenerate

    sbx_recomb u_recomb (
        .hi  (c_hi),
        .lo  (c_lo),
        .ninv(c_ninv),
        .qhi (c_qhi),
        .qlo (c_qlo)
    );

    generate
        if (CUT_MUL) begin : g_cut_mul
            sbx_pipe_reg #(.WIDTH(W_M)) u_reg (
                .clk (clk),
                .rst_n(rst_n),
                .vin (vc),
                .din ({c_qhi, c_qlo}),
                .vout(vd),
                .dout({d_qhi, d_qlo})
            );
        end else begin : g_pass_mul
            assign {d_qhi, d_qlo} = {c_qhi, c_qlo};
            assign vd = vc;
        end
    endgenerate

    // merged back-map and affine step
    always_comb begin
        out_byte  = mat_apply(MAP_OUT, {d_qhi, d_qlo}) ^ AFF_CONST;
        out_valid = vd;
    end
endmodule

// File: rtl/sbox_tower_chk.sv
module sbox_tower_chk #(
    parameter int STAGES = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_byte,
    input logic       out_valid,
    input logic [7:0] out_byte
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    generate
        if (STAGES > 0) begin : g_seq
            assert_valid_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (32'(since_rst) >= STAGES) |-> (out_valid == $past(in_valid, STAGES)));

            assert_zero_to_63_R2: assert property (@(posedge clk) disable iff (!rst_n)
                ((32'(since_rst) >= STAGES) && out_valid && ($past(in_byte, STAGES) == 8'h00))
                |-> (out_byte == 8'h63));

            assert_no_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
                ((32'(since_rst) >= STAGES) && out_valid)
                |-> ((out_byte != $past(in_byte, STAGES)) && (out_byte != ~$past(in_byte, STAGES))));

            assert_reset_idle_R6: assert property (@(posedge clk)
                !rst_n |-> !out_valid);
        end else begin : g_comb
            assert_zero_to_63_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && (in_byte == 8'h00)) |-> (out_byte == 8'h63));

            assert_no_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |-> ((out_byte != in_byte) && (out_byte != ~in_byte)));

            assert_same_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |-> out_valid);

            assert_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |-> !out_valid);
        end
    endgenerate
endmodule

bind sbox_tower_pipe sbox_tower_chk #(.STAGES(STAGES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .out_valid(out_valid),
    .out_byte (out_byte)
);

// File: tb/tb_sbox_tower_pipe.sv
`timescale 1ns/1ps
module tb_sbox_tower_pipe;

    typedef struct packed {
        logic [7:0] inb;
        logic [7:0] exp;
        int         cyc;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;

    logic       v0, v2, v3;
    logic [7:0] o0, o2, o3;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [7:0] ref_tab [256];
    item_t q0[$];
    item_t q2[$];
    item_t q3[$];

    always #2 clk = ~clk;  // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    sbox_tower_pipe #(.STAGES(0)) dut_s0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(v0), .out_byte(o0));

    sbox_tower_pipe #(.STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(v2), .out_byte(o2));

    sbox_tower_pipe #(.STAGES(3)) dut_s3 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(v3), .out_byte(o3));

    // independent reference: brute-force inverse plus rotate-xor affine
    function automatic logic [7:0] fmul(logic [7:0] a, logic [7:0] b);
        logic [7:0] r = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl(logic [7:0] x, int n);
        return (x << n) | (x >> (8 - n));
    endfunction

    function automatic logic [7:0] ref_sub(logic [7:0] x);
        logic [7:0] inv = 8'h00;
        for (int c = 1; c < 256; c++) begin
            if (x != 8'h00 && fmul(x, 8'(c)) == 8'h01) inv = 8'(c);
        end
        return inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ 8'h63;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver: one byte in the next cycle, expected items queued
    task automatic send(input logic [7:0] b);
        item_t it;
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_byte  = b;
        it.inb = b;
        it.exp = ref_tab[b];
        it.cyc = cyc;
        q0.push_back(it);
        q2.push_back(it);
        q3.push_back(it);
    endtask

    task automatic bubble();
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_byte  = 8'hA5;
    endtask

    task automatic mon(input int k, input int st, input logic v, input logic [7:0] o);
        item_t it;
        bit have = 1'b0;
        if (!v) return;
        case (k)
            0: if (q0.size() > 0) begin it = q0.pop_front(); have = 1'b1; end
            1: if (q2.size() > 0) begin it = q2.pop_front(); have = 1'b1; end
            default: if (q3.size() > 0) begin it = q3.pop_front(); have = 1'b1; end
        endcase
        // R7: an output with nothing issued is a spurious result
        check(have, "R7", $sformatf("spurious output st=%0d", st), 1, 0);
        if (!have) return;
        if (it.inb == 8'h00)
            check(o == 8'h63, "R2", $sformatf("zero input st=%0d", st), o, 8'h63);
        check(o == it.exp, "R1", $sformatf("sbox(%02h) st=%0d", it.inb, st), o, it.exp);
        if (st == 0)
            check(cyc == it.cyc, "R4", "same-cycle output", cyc - it.cyc, 0);
        else
            check(cyc - it.cyc == st, "R3", $sformatf("latency st=%0d", st), cyc - it.cyc, st);
        check(o != it.inb && o != ~it.inb, "R8", $sformatf("fixed point st=%0d", st), o, it.inb);
    endtask

    // monitor at the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            check(!v2, "R6", "out_valid in reset st=2", v2, 0);
            check(!v3, "R6", "out_valid in reset st=3", v3, 0);
        end else begin
            mon(0, 0, v0, o0);
            mon(1, 2, v2, o2);
            mon(2, 3, v3, o3);
        end
    end

    task automatic drain_and_check(input string tag);
        repeat (6) bubble();
        @(negedge clk);
        check(q0.size() == 0, "R5", {tag, " pending st=0"}, q0.size(), 0);
        check(q2.size() == 0, "R5", {tag, " pending st=2"}, q2.size(), 0);
        check(q3.size() == 0, "R5", {tag, " pending st=3"}, q3.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ref_tab[i] = ref_sub(8'(i));
        #1 rst_n = 1'b0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 R5: dense ascending sweep of all 256 values
        for (int i = 0; i < 256; i++) send(8'(i));
        drain_and_check("dense sweep");

        // R7: descending sweep with a bubble after every second byte
        for (int i = 255; i >= 0; i--) begin
            send(8'(i));
            if (i % 2 == 0) bubble();
        end
        drain_and_check("bubbled sweep");

        // R2 R8: zero and all-ones alternating, plus repeated zeros
        for (int i = 0; i < 8; i++) send((i % 2 == 0) ? 8'h00 : 8'hFF);
        for (int i = 0; i < 4; i++) send(8'h00);
        drain_and_check("zero pattern");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule